// File: doc/BRIEF.md
# Performance Counter Bank with Snapshot

This block keeps eight 32-bit event counters and one 40-bit cycle counter. Each counter advances by one on a cycle where its own strobe input is high and the bank's global enable is set. Neighbouring event counters (2k and 2k+1) can be joined into a single 64-bit counter. In that mode the lower half carries into the upper half, and the upper half's own strobe is ignored.

Every counter wrap sets a bit in a 9-bit sticky overflow vector. Software clears these bits by writing ones, and the vector can drive an interrupt. A snapshot can be triggered by a register write or by an external pin. It copies every live counter into a matching shadow register in one clock edge and raises a snapshot status flag. A control bit can make the same snapshot zero the live counters. Software reaches the bank through a simple word-addressed register port: the write takes effect at the clock edge, and the read data is combinational from the address.

Top module: `pmc_bank`

Register index map (6-bit `reg_addr`):
- Live counters: event counters at 0..7, cycle counter at 8.
- Shadow registers: event shadows at 16..23, cycle shadow at 24.
- Status and commands: overflow status at 32, overflow clear at 33, control at 34, snapshot status at 35, snapshot request at 36, snapshot status clear at 37.

## Requirements
- R1: After synchronous reset, every live counter, shadow, control bit, overflow bit and the snapshot status reads zero, and `irq` is low.
- R2: Control bit 0 is the global enable. With it set, event counter i (index i) increases by one on each cycle where `evt_stb[i]` is high. With it clear, no counter moves.
- R3: The 40-bit cycle counter (index 8) increases on `cyc_stb` while enabled. Going from all-ones to zero sets overflow bit 8.
- R4: An unchained event counter i going from 0xFFFFFFFF to 0 sets overflow bit i.
- R5: Control bit 1+k chains counters 2k and 2k+1. A wrap of the lower counter adds one to the upper counter, and `evt_stb[2k+1]` is ignored. Overflow bit 2k is never set by the pair. Overflow bit 2k+1 is set only when the full 64-bit value wraps.
- R6: Overflow status (index 32) is sticky. Writing to index 33 clears each bit where the written data has a one and leaves the other bits alone. A new overflow in the same cycle keeps its bit set.
- R7: `irq` is high exactly when control bit 6 is set and at least one overflow status bit is set.
- R8: A snapshot is triggered by `snap_req` high, or by a write to index 36 with data bit 0 set. At that edge every shadow takes the live value held before the edge, and snapshot status (index 35, bit 0) is set. A snapshot takes priority over a software write to a shadow.
- R9: With control bit 5 set, a snapshot also zeroes every live counter. An increment in the same cycle is lost, while the shadow still receives the value from before the increment.
- R10: Writing to index 37 with data bit 0 set clears the snapshot status, unless a snapshot occurs in the same cycle.
- R11: A write to a live counter or shadow index loads the data and takes priority over an increment in the same cycle. Write-only and unused indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | 8 | Per-counter event strobes |
| cyc_stb | input | 1 | Cycle counter strobe |
| snap_req | input | 1 | External snapshot request |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 40 | Register write data |
| reg_rdata | output | 40 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench goes after the counter wrap points. Counters are preloaded just below all-ones, so a chained pair that fails to suppress its lower overflow bit, or fails to ignore its upper strobe, shows a wrong status or a wrong upper count. A snapshot is fired in the same cycle as increments with clearing enabled: a design that samples after the increment puts a shadow one too high, and one that lets the increment win leaves a non-zero live value. A software write is made to collide with a strobe, and overflow clears are made to collide with new wraps, which exposes any wrong priority. Long random runs with software writes, clears and pin requests mixed in are compared against a bench model, with `irq` checked every cycle.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
    localparam int NUM_PAIRS = 4;
    localparam int NUM_EVT   = 2 * NUM_PAIRS;
    localparam int EVT_W     = 32;
    localparam int CYC_W     = 40;
    localparam int DATA_W    = CYC_W;
    localparam int ADDR_W    = 6;
    localparam int OVF_W     = NUM_EVT + 1;

    localparam int A_EVT       = 0;
    localparam int A_CYC       = A_EVT + NUM_EVT;
    localparam int A_SH_EVT    = 16;
    localparam int A_SH_CYC    = A_SH_EVT + NUM_EVT;
    localparam int A_OVF       = 32;
    localparam int A_OVF_CLR   = 33;
    localparam int A_CTRL      = 34;
    localparam int A_SNAP_STAT = 35;
    localparam int A_SNAP_REQ  = 36;
    localparam int A_SNAP_CLR  = 37;

    // bit 6 irq_en, bit 5 zero_on_snap, bits 4:1 chain, bit 0 enable
    typedef struct packed {
        logic                 irq_en;
        logic                 zero_on_snap;
        logic [NUM_PAIRS-1:0] chain;
        logic                 enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic hit(input logic [ADDR_W-1:0] addr, input int target);
        return addr == ADDR_W'(target);
    endfunction
endpackage

// File: rtl/pmc_pair.sv
`timescale 1ns/1ps
module pmc_pair #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              chain,
    input  logic              zero,
    input  logic              snap,
    input  logic [1:0]        strobe,
    input  logic [1:0]        wr_live,
    input  logic [1:0]        wr_shadow,
    input  logic [W-1:0]      wdata,
    output logic [1:0][W-1:0] live_o,
    output logic [1:0][W-1:0] shadow_o,
    output logic [1:0]        ovf_set
);
    logic [1:0][W-1:0] live_q, shadow_q;
    logic [1:0]        inc, wrap;

    always_comb begin
        inc[0]  = en & strobe[0] & ~zero & ~wr_live[0];
        wrap[0] = inc[0] & (&live_q[0]);
        inc[1]  = en & ~zero & ~wr_live[1] & (chain ? wrap[0] : strobe[1]);
        wrap[1] = inc[1] & (&live_q[1]);
    end

    assign ovf_set  = {wrap[1], wrap[0] & ~chain};
    assign live_o   = live_q;
    assign shadow_o = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= '0;
            shadow_q <= '0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (zero)            live_q[i] <= '0;
                else if (wr_live[i]) live_q[i] <= wdata;
                else if (inc[i])     live_q[i] <= live_q[i] + W'(1);
                if (snap)              shadow_q[i] <= live_q[i];
                else if (wr_shadow[i]) shadow_q[i] <= wdata;
            end
        end
    end

    // R2: an enabled strobe with no competing write or clear advances the lower counter
    assert_lo_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && strobe[0] && !zero && !wr_live[0]) |=> live_q[0] == $past(live_q[0]) + W'(1));
    // R5: in chained mode the upper counter moves only via carry
    assert_chain_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (chain && !strobe[0] && !zero && !wr_live[1]) |=> $stable(live_q[1]));
    // R8: shadow captures pre-edge live value
    assert_shadow_R8: assert property (@(posedge clk) disable iff (rst)
        snap |=> shadow_q == $past(live_q));
    // R9: clearing snapshot leaves live counters at zero
    assert_zero_R9: assert property (@(posedge clk) disable iff (rst)
        zero |=> live_q == '0);
endmodule

// File: rtl/pmc_cyc.sv
`timescale 1ns/1ps
module pmc_cyc #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         zero,
    input  logic         snap,
    input  logic         strobe,
    input  logic         wr_live,
    input  logic         wr_shadow,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] live_o,
    output logic [W-1:0] shadow_o,
    output logic         ovf_set
);
    logic [W-1:0] live_q, shadow_q;
    logic         inc;

    assign inc      = en & strobe & ~zero & ~wr_live;
    assign ovf_set  = inc & (&live_q);
    assign live_o   = live_q;
    assign shadow_o = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (zero)         live_q <= '0;
            else if (wr_live) live_q <= wdata;
            else if (inc)     live_q <= live_q + W'(1);
            if (snap)           shadow_q <= live_q;
            else if (wr_shadow) shadow_q <= wdata;
        end
    end

    // R3: with the bank disabled the cycle counter holds
    assert_cyc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !zero && !wr_live) |=> $stable(live_q));
    // R11: a software load wins over a same-cycle increment
    assert_cyc_load_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_live && !zero) |=> live_q == $past(wdata));
endmodule

// File: rtl/pmc_ctrl.sv
`timescale 1ns/1ps
module pmc_ctrl
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_ctrl,
    input  logic             we_ovf_clr,
    input  logic             we_snap_req,
    input  logic             we_snap_clr,
    input  logic [OVF_W-1:0] wdata,
    input  logic             snap_pin,
    input  logic [OVF_W-1:0] ovf_set,
    output ctrl_t            ctrl_o,
    output logic [OVF_W-1:0] ovf_o,
    output logic             snap_stat_o,
    output logic             snap_o,
    output logic             irq_o
);
    ctrl_t            ctrl_q;
    logic [OVF_W-1:0] ovf_q;
    logic             snap_q;

    assign snap_o      = snap_pin | (we_snap_req & wdata[0]);
    assign ctrl_o      = ctrl_q;
    assign ovf_o       = ovf_q;
    assign snap_stat_o = snap_q;
    assign irq_o       = ctrl_q.irq_en & (|ovf_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovf_q  <= '0;
            snap_q <= 1'b0;
        end else begin
            if (we_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            ovf_q  <= (ovf_q & ~(we_ovf_clr ? wdata : '0)) | ovf_set;
            snap_q <= (snap_q & ~(we_snap_clr & wdata[0])) | snap_o;
        end
    end

    // R6: without a clear, no status bit drops
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !we_ovf_clr |=> (ovf_q & $past(ovf_q)) == $past(ovf_q));
    // R6: cleared bits are zero when no new overflow arrives
    assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (we_ovf_clr && ovf_set == '0) |=> (ovf_q & $past(wdata)) == '0);
    // R7: an enabled overflow raises the interrupt on the next cycle
    assert_irq_R7: assert property (@(posedge clk) disable iff (rst)
        ((|ovf_set) && ctrl_q.irq_en && !we_ctrl) |=> irq_o);
    // R8: a snapshot sets the status
    assert_snap_set_R8: assert property (@(posedge clk) disable iff (rst)
        snap_o |=> snap_q);
    // R10: a clear without a concurrent snapshot drops the status
    assert_snap_clr_R10: assert property (@(posedge clk) disable iff (rst)
        (we_snap_clr && wdata[0] && !snap_o) |=> !snap_q);
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
    import pmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_stb,
    input  logic               cyc_stb,
    input  logic               snap_req,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    ctrl_t                           ctrl;
    logic [OVF_W-1:0]                ovf_stat, ovf_set;
    logic                            snap_stat, snap, zero;
    logic [NUM_EVT-1:0][EVT_W-1:0]   evt_live, evt_shadow;
    logic [NUM_EVT-1:0]              evt_wr_live, evt_wr_sh;
    logic [CYC_W-1:0]                cyc_live, cyc_shadow;

    assign zero = snap & ctrl.zero_on_snap;

    pmc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .we_ctrl     (reg_we & hit(reg_addr, A_CTRL)),
        .we_ovf_clr  (reg_we & hit(reg_addr, A_OVF_CLR)),
        .we_snap_req (reg_we & hit(reg_addr, A_SNAP_REQ)),
        .we_snap_clr (reg_we & hit(reg_addr, A_SNAP_CLR)),
        .wdata       (reg_wdata[OVF_W-1:0]),
        .snap_pin    (snap_req),
        .ovf_set     (ovf_set),
        .ctrl_o      (ctrl),
        .ovf_o       (ovf_stat),
        .snap_stat_o (snap_stat),
        .snap_o      (snap),
        .irq_o       (irq)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_dec
        assign evt_wr_live[i] = reg_we & hit(reg_addr, A_EVT + i);
        assign evt_wr_sh[i]   = reg_we & hit(reg_addr, A_SH_EVT + i);
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        pmc_pair #(.W(EVT_W)) u_pair (
            .clk       (clk),
            .rst       (rst),
            .en        (ctrl.enable),
            .chain     (ctrl.chain[p]),
            .zero      (zero),
            .snap      (snap),
            .strobe    (evt_stb[2*p +: 2]),
            .wr_live   (evt_wr_live[2*p +: 2]),
            .wr_shadow (evt_wr_sh[2*p +: 2]),
            .wdata     (reg_wdata[EVT_W-1:0]),
            .live_o    (evt_live[2*p +: 2]),
            .shadow_o  (evt_shadow[2*p +: 2]),
            .ovf_set   (ovf_set[2*p +: 2])
        );
    end

    pmc_cyc #(.W(CYC_W)) u_cyc (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.enable),
        .zero      (zero),
        .snap      (snap),
        .strobe    (cyc_stb),
        .wr_live   (reg_we & hit(reg_addr, A_CYC)),
        .wr_shadow (reg_we & hit(reg_addr, A_SH_CYC)),
        .wdata     (reg_wdata),
        .live_o    (cyc_live),
        .shadow_o  (cyc_shadow),
        .ovf_set   (ovf_set[NUM_EVT])
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (hit(reg_addr, A_EVT + i))    reg_rdata = DATA_W'(evt_live[i]);
            if (hit(reg_addr, A_SH_EVT + i)) reg_rdata = DATA_W'(evt_shadow[i]);
        end
        if (hit(reg_addr, A_CYC))       reg_rdata = cyc_live;
        if (hit(reg_addr, A_SH_CYC))    reg_rdata = cyc_shadow;
        if (hit(reg_addr, A_OVF))       reg_rdata = DATA_W'(ovf_stat);
        if (hit(reg_addr, A_CTRL))      reg_rdata = DATA_W'(ctrl);
        if (hit(reg_addr, A_SNAP_STAT)) reg_rdata = DATA_W'(snap_stat);
    end
endmodule

// File: tb/pmc_bank_tb.sv
`timescale 1ns/1ps
module pmc_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_stb = '0;
    logic        cyc_stb = 1'b0;
    logic        snap_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [39:0] reg_wdata = '0;
    logic [39:0] reg_rdata;
    logic        irq;

    pmc_bank u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_evt [8];
    logic [31:0] m_sh  [8];
    logic [39:0] m_cyc, m_shc;
    logic [8:0]  m_ovf;
    logic        m_snap;
    logic [6:0]  m_ctrl;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] exp_rd(input int a);
        if (a < 8)             return {8'b0, m_evt[a]};
        if (a == 8)            return m_cyc;
        if (a >= 16 && a < 24) return {8'b0, m_sh[a-16]};
        if (a == 24)           return m_shc;
        if (a == 32)           return {31'b0, m_ovf};
        if (a == 34)           return {33'b0, m_ctrl};
        if (a == 35)           return {39'b0, m_snap};
        return '0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_evt[i] = '0; m_sh[i] = '0; end
        m_cyc = '0; m_shc = '0; m_ovf = '0; m_snap = 1'b0; m_ctrl = '0;
    endtask

    task automatic model_step(input logic [7:0] es, input logic cs, input logic sp,
                              input logic we, input int a, input logic [39:0] wd);
        logic snap, zero, en, li, lw, hi_i, hw, ci;
        logic [31:0] ne [8];
        logic [39:0] nc;
        logic [8:0]  set;
        snap = sp | (we && a == 36 && wd[0]);
        zero = snap & m_ctrl[5];
        en   = m_ctrl[0];
        set  = '0;
        for (int p = 0; p < 4; p++) begin
            li   = en && es[2*p] && !zero && !(we && a == 2*p);
            lw   = li && (m_evt[2*p] == 32'hFFFF_FFFF);
            hi_i = en && !zero && !(we && a == 2*p+1) && (m_ctrl[1+p] ? lw : es[2*p+1]);
            hw   = hi_i && (m_evt[2*p+1] == 32'hFFFF_FFFF);
            ne[2*p]   = zero ? 32'h0 : (we && a == 2*p)   ? wd[31:0] : li   ? m_evt[2*p] + 1   : m_evt[2*p];
            ne[2*p+1] = zero ? 32'h0 : (we && a == 2*p+1) ? wd[31:0] : hi_i ? m_evt[2*p+1] + 1 : m_evt[2*p+1];
            if (lw && !m_ctrl[1+p]) set[2*p] = 1'b1;
            if (hw) set[2*p+1] = 1'b1;
        end
        ci = en && cs && !zero && !(we && a == 8);
        if (ci && m_cyc == 40'hFF_FFFF_FFFF) set[8] = 1'b1;
        nc = zero ? 40'h0 : (we && a == 8) ? wd : ci ? m_cyc + 1 : m_cyc;
        for (int i = 0; i < 8; i++) begin
            if (snap) m_sh[i] = m_evt[i];
            else if (we && a == 16 + i) m_sh[i] = wd[31:0];
        end
        if (snap) m_shc = m_cyc;
        else if (we && a == 24) m_shc = wd;
        m_ovf  = (m_ovf & ~((we && a == 33) ? wd[8:0] : 9'h0)) | set;
        m_snap = (m_snap & ~(we && a == 37 && wd[0])) | snap;
        if (we && a == 34) m_ctrl = wd[6:0];
        for (int i = 0; i < 8; i++) m_evt[i] = ne[i];
        m_cyc = nc;
    endtask

    task automatic cyc(input logic [7:0] es, input logic cs, input logic sp,
                       input logic we, input int a, input logic [39:0] wd);
        @(negedge clk);
        evt_stb = es; cyc_stb = cs; snap_req = sp;
        reg_we = we; reg_addr = 6'(a); reg_wdata = wd;
        @(posedge clk);
        model_step(es, cs, sp, we, a, wd);
    endtask

    task automatic wr(input int a, input logic [39:0] wd);
        cyc(8'h0, 1'b0, 1'b0, 1'b1, a, wd);
    endtask

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        evt_stb = '0; cyc_stb = 1'b0; snap_req = 1'b0; reg_we = 1'b0;
        reg_addr = 6'(a);
        #1;
        check(tag, {24'b0, reg_rdata}, {24'b0, exp_rd(a)});
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        evt_stb = '0; cyc_stb = 1'b0; snap_req = 1'b0; reg_we = 1'b0;
        #1;
        check(tag, {63'b0, irq}, {63'b0, (m_ctrl[6] && (|m_ovf))});
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a <= 8; a++) rd_chk(a, tag);
        for (int a = 16; a <= 24; a++) rd_chk(a, tag);
        rd_chk(32, tag); rd_chk(33, tag); rd_chk(34, tag); rd_chk(35, tag);
        rd_chk(36, tag); rd_chk(37, tag); rd_chk(40, tag);
        irq_chk(tag);
    endtask

    task automatic lit_chk(input int a, input logic [39:0] exp, input string tag);
        @(negedge clk);
        evt_stb = '0; cyc_stb = 1'b0; snap_req = 1'b0; reg_we = 1'b0;
        reg_addr = 6'(a);
        #1;
        check(tag, {24'b0, reg_rdata}, {24'b0, exp});
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        read_all("R1 reset state");

        // R2: counting while enabled, then frozen while disabled
        wr(34, 40'h1);
        repeat (3) cyc(8'b1010_0101, 1'b1, 1'b0, 1'b0, 0, '0);
        read_all("R2 enabled count");
        lit_chk(0, 40'd3, "R2 literal count");
        wr(34, 40'h0);
        repeat (3) cyc(8'hFF, 1'b1, 1'b0, 1'b0, 0, '0);
        read_all("R2 disabled hold");

        // R11: load beats strobe, write-only reads zero
        wr(34, 40'h1);
        cyc(8'h08, 1'b0, 1'b0, 1'b1, 3, 40'hFFFF_FFFE);
        lit_chk(3, 40'hFFFF_FFFE, "R11 load priority");
        rd_chk(33, "R11 write-only reads zero");

        // R4: wrap of unchained counter
        repeat (2) cyc(8'h08, 1'b0, 1'b0, 1'b0, 0, '0);
        lit_chk(32, 40'h008, "R4 overflow bit3");
        read_all("R4 wrap");

        // R7: interrupt gated by enable
        irq_chk("R7 irq masked");
        wr(34, 40'h41);
        irq_chk("R7 irq raised");

        // R6: partial clear keeps bit, exact clear drops it
        wr(33, 40'h0F0);
        lit_chk(32, 40'h008, "R6 untouched bit");
        wr(33, 40'h008);
        lit_chk(32, 40'h000, "R6 cleared");
        irq_chk("R7 irq after clear");
        // R6: new overflow in the same cycle as its clear
        wr(0, 40'hFFFF_FFFF);
        cyc(8'h01, 1'b0, 1'b0, 1'b1, 33, 40'h001);
        lit_chk(32, 40'h001, "R6 set beats clear");
        wr(33, 40'h1FF);

        // R5: chain pair 1
        wr(34, 40'h05);
        wr(2, 40'hFFFF_FFFF);
        wr(3, 40'h5);
        cyc(8'h0C, 1'b0, 1'b0, 1'b0, 0, '0);
        lit_chk(2, 40'h0, "R5 lower wraps");
        lit_chk(3, 40'h6, "R5 carry, upper strobe ignored");
        lit_chk(32, 40'h000, "R5 no lower overflow");
        wr(2, 40'hFFFF_FFFF);
        wr(3, 40'hFFFF_FFFF);
        cyc(8'h04, 1'b0, 1'b0, 1'b0, 0, '0);
        lit_chk(32, 40'h008, "R5 full 64-bit wrap");
        read_all("R5 chain");
        wr(33, 40'h1FF);

        // R3: cycle counter wrap
        wr(8, 40'hFF_FFFF_FFFF);
        cyc(8'h0, 1'b1, 1'b0, 1'b0, 0, '0);
        lit_chk(8, 40'h0, "R3 cycle wrap");
        lit_chk(32, 40'h100, "R3 overflow bit8");

        // R8: pin snapshot, R10 clear, R8 register snapshot
        wr(34, 40'h01);
        wr(5, 40'h1234);
        cyc(8'h20, 1'b1, 1'b1, 1'b0, 0, '0);
        lit_chk(21, 40'h1234, "R8 shadow pre-edge");
        lit_chk(5, 40'h1235, "R8 live keeps counting");
        lit_chk(35, 40'h1, "R8 status set");
        read_all("R8 pin snapshot");
        wr(37, 40'h1);
        lit_chk(35, 40'h0, "R10 status cleared");
        wr(36, 40'h1);
        read_all("R8 register snapshot");
        cyc(8'h0, 1'b0, 1'b1, 1'b1, 37, 40'h1);
        lit_chk(35, 40'h1, "R10 snapshot beats clear");

        // R9: clearing snapshot with colliding increments
        wr(34, 40'h21);
        wr(6, 40'h77);
        cyc(8'hFF, 1'b1, 1'b1, 1'b0, 0, '0);
        lit_chk(22, 40'h77, "R9 shadow pre-increment");
        lit_chk(6, 40'h0, "R9 live zeroed");
        read_all("R9 clear snapshot");

        // random phase: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 against the model
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  es;
            logic        cs, sp, we;
            int          a, sel;
            logic [39:0] wd;
            es = 8'($urandom);
            cs = 1'($urandom);
            sp = ($urandom_range(0, 15) == 0);
            we = ($urandom_range(0, 3) == 0);
            sel = $urandom_range(0, 15);
            a = 40; wd = '0;
            if (sel < 8)       begin a = sel; wd = {8'h0, 24'hFF_FFFF, 8'($urandom)}; end
            else if (sel == 8) begin a = 8;   wd = {32'hFFFF_FFFF, 8'($urandom)}; end
            else if (sel == 9) begin a = 34;  wd = {33'h0, 6'($urandom), ($urandom_range(0, 7) != 0)}; end
            else if (sel == 10) begin a = 33; wd = 40'($urandom_range(0, 511)); end
            else if (sel == 11) begin a = 36; wd = 40'h1; end
            else if (sel == 12) begin a = 37; wd = 40'h1; end
            else if (sel == 13) begin a = $urandom_range(16, 24); wd = {8'h0, 32'($urandom)}; end
            else we = 1'b0;
            cyc(es, cs, sp, we, a, wd);
            irq_chk("R7 random irq");
            if (n % 64 == 63) read_all("R2/R5/R6/R8/R9/R11 random");
        end

        summary();
    end
endmodule